// File: doc/BRIEF.md
# Width-Aware Bus Control Signal Driver

This block produces the per-transaction control pins of a multiplexed 32-bit external bus master. It accepts one aligned request at a time. A request carries the two low address bits, a four-lane byte mask, a write flag, a data/instruction flag, the width of the target memory region (8, 16 or 32 bits) and a burst length. The block then runs the request through one address cycle, one or more data cycles and one recovery cycle. During these phases it drives four active-low byte-enable pins, a two-bit width/halted code, a write flag and a data flag.

The byte-enable pins change meaning with the region width. On a 32-bit region each pin qualifies one byte lane. On a 16-bit region two pins act as high and low byte strobes, one pin carries address bit 1 and one is parked high. On an 8-bit region two pins carry address bits 1 and 0 and the other two are parked high. For narrow regions these address bits step forward on every data beat of a burst. A hold request/acknowledge pair lets another master take the bus. The block grants it only between transactions and then releases every control pin through a single output-enable signal.

Top module: `bus_ctl_driver`

## Requirements
- R1: For a 32-bit region (req_width 2'b10), during the address and data phases be_n[i] is the inverse of the captured mask bit i, for i = 0..3.
- R2: For a 16-bit region (req_width 2'b01), during the address and data phases be_n[3] = ~mask[1] (high byte), be_n[0] = ~mask[0] (low byte), be_n[2] = 1, and be_n[1] carries the current address bit 1.
- R3: For an 8-bit region (req_width 2'b00), during the address and data phases be_n[3:2] = 2'b11 and be_n[1:0] carry the current address bits 1:0.
- R4: width_code shows the captured region width (00 = 8-bit, 01 = 16-bit, 10 = 32-bit) in the address, data and recovery phases. Outside a transaction it is 11 if the halted input was high in the previous cycle, and 00 otherwise.
- R5: An accepted request gives exactly one address cycle, then req_beats+1 data cycles, then one recovery cycle. bus_phase reads 01 for address, 10 for data, 11 for recovery and 00 otherwise.
- R6: wr_flag (1 = write) and dc_flag (1 = data access) are captured when the request is accepted. They hold their values from the address phase through the recovery phase and are 0 outside a transaction.
- R7: be_n does not change from one data cycle to the next on a 32-bit region. It is 4'b1111 in the recovery phase and whenever no transaction is in progress.
- R8: On narrow regions the address bits on the enable pins start at req_addr_lo and advance after each data cycle by 1 (8-bit) or by 2 (16-bit), modulo 4.
- R9: A hold_req that arrives during a transaction is granted only after the recovery cycle. hold_ack rises in the same cycle that ctl_oe falls to 0. Both stay there while hold_req is high, and the block returns to idle in the cycle after hold_req drops.
- R10: req_ready is high only when the block is idle and hold_req is low. A req_valid presented while req_ready is low has no effect on any output.
- R11: During and right after synchronous reset, be_n = 4'b1111, wr_flag = 0, dc_flag = 0, width_code = 00, hold_ack = 0, ctl_oe = 1 and bus_phase = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr_lo | input | 2 | Low address bits of the first beat |
| req_mask | input | 4 | Byte lanes wanted, active high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_width | input | 2 | Region width: 00 = 8, 01 = 16, 10 = 32 bits |
| req_beats | input | BEAT_W | Number of data beats minus one |
| halted | input | 1 | Processor is halted |
| hold_req | input | 1 | Another master asks for the bus |
| hold_ack | output | 1 | Bus released to the other master |
| bus_phase | output | 2 | 00 idle/hold, 01 address, 10 data, 11 recovery |
| be_n | output | 4 | Byte enables / strobes / low address bits |
| width_code | output | 2 | Region width or halted code |
| wr_flag | output | 1 | Write flag |
| dc_flag | output | 1 | Data/instruction flag |
| ctl_oe | output | 1 | Output enable for all control pins (0 = high impedance) |

## Verification
Several properties are checked on every cycle by the assertions. The address phase is always followed by a data phase. Captured attributes never change except at acceptance. Enables stay stable across 32-bit data beats, and the parked pins stay high on 8-bit regions. The halted code appears only while idle. Hold is entered only from recovery or idle, and acknowledge always comes with the outputs released. Other behaviours can only be shown by the bench's scenarios: the exact pin mapping for each width, the address bits stepping through a narrow burst, the exact beat count, the delay of a hold that arrives mid-burst, and requests presented while the block is busy or held being ignored.

// File: rtl/bcd_pkg.sv
// Package: shared types for the bus control driver.
// Assumes four byte lanes on the external bus.
package bcd_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        RW_8    = 2'b00,
        RW_16   = 2'b01,
        RW_32   = 2'b10,
        RW_HALT = 2'b11
    } wcode_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_DATA  = 3'd2,
        PH_RECOV = 3'd3,
        PH_HOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [LANES-1:0] mask;
        wcode_e           width;
        logic             wr;
        logic             dc;
    } attr_t;
endpackage

// File: rtl/bcd_seq.sv
// Module: bcd_seq
// Phase sequencer: idle -> address -> data beats -> recovery -> idle or hold.
// Assumes req_beats is the number of data beats minus one. Hold is granted
// only from idle or at the end of recovery.
module bcd_seq
    import bcd_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              hold_req,
    input  logic [BEAT_W-1:0] req_beats,
    output phase_e            phase,
    output logic              accept,
    output logic              beat_adv
);
    logic [BEAT_W-1:0] beats_left;
    logic              last_beat;

    // Purpose: decode the acceptance and beat-advance strobes.
    always_comb begin
        accept    = (phase == PH_IDLE) && req_valid && !hold_req;
        last_beat = (beats_left == '0);
        beat_adv  = (phase == PH_DATA) && !last_beat;
    end

    // Purpose: phase register and remaining-beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            beats_left <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (hold_req) begin
                        phase <= PH_HOLD;
                    end else if (req_valid) begin
                        phase      <= PH_ADDR;
                        beats_left <= req_beats;
                    end
                end
                PH_ADDR:  phase <= PH_DATA;
                PH_DATA: begin
                    if (last_beat) phase <= PH_RECOV;
                    else           beats_left <= beats_left - 1'b1;
                end
                PH_RECOV: phase <= hold_req ? PH_HOLD : PH_IDLE;
                PH_HOLD:  if (!hold_req) phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R5: an address cycle is always followed by a data cycle.
    a_r5_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR) |=> (phase == PH_DATA));

    // R9: hold is entered only from recovery or idle.
    a_r9_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_HOLD) && ($past(phase) != PH_HOLD)) |->
        (($past(phase) == PH_RECOV) || ($past(phase) == PH_IDLE)));

    // R9: hold is left only once hold_req has dropped.
    a_r9_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(phase) == PH_HOLD) && (phase != PH_HOLD)) |-> !$past(hold_req));
endmodule

// File: rtl/bcd_attr.sv
// Module: bcd_attr
// Captures the request attributes on acceptance and steps the low address
// bits on each non-final data beat by the region's byte width.
// Assumes the request is aligned to the region width.
module bcd_attr
    import bcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             beat_adv,
    input  logic [LANES-1:0] req_mask,
    input  wcode_e           req_width,
    input  logic             req_wr,
    input  logic             req_dc,
    input  logic [1:0]       req_alo,
    output attr_t            attr,
    output logic [1:0]       alo
);
    logic [1:0] step;

    // Purpose: address increment per beat for the captured width.
    always_comb begin
        case (attr.width)
            RW_8:    step = 2'd1;
            RW_16:   step = 2'd2;
            default: step = 2'd0;
        endcase
    end

    // Purpose: attribute capture and address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr <= '{mask: '0, width: RW_8, wr: 1'b0, dc: 1'b0};
            alo  <= 2'd0;
        end else if (accept) begin
            attr <= '{mask: req_mask, width: req_width, wr: req_wr, dc: req_dc};
            alo  <= req_alo;
        end else if (beat_adv) begin
            alo  <= alo + step;
        end
    end

    // R6: captured attributes change only at acceptance.
    a_r6_attr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(attr));

    // R8: address bits move only on acceptance or a beat advance.
    a_r8_alo_moves_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !beat_adv) |=> $stable(alo));
endmodule

// File: rtl/bcd_lane_map.sv
// Module: bcd_lane_map
// Maps phase, captured attributes and address bits onto the pin values:
// byte enables (active low), width/halted code, write and data flags.
// Assumes halt_q is already registered by the caller.
module bcd_lane_map
    import bcd_pkg::*;
(
    input  phase_e           phase,
    input  attr_t            attr,
    input  logic [1:0]       alo,
    input  logic             halt_q,
    output logic [LANES-1:0] be_n,
    output logic [1:0]       width_code,
    output logic             wr_flag,
    output logic             dc_flag
);
    logic [LANES-1:0] wide_n;
    logic             strobe_phase;
    logic             busy;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wide_n[i] = ~attr.mask[i];
    end

    // Purpose: select the pin meaning for the current phase and width.
    always_comb begin
        strobe_phase = (phase == PH_ADDR) || (phase == PH_DATA);
        busy         = strobe_phase || (phase == PH_RECOV);
        be_n         = '1;
        if (strobe_phase) begin
            case (attr.width)
                RW_8:    be_n = {2'b11, alo};
                RW_16:   be_n = {wide_n[1], 1'b1, alo[1], wide_n[0]};
                default: be_n = wide_n;
            endcase
        end
        if (busy) begin
            width_code = attr.width;
            wr_flag    = attr.wr;
            dc_flag    = attr.dc;
        end else begin
            width_code = halt_q ? RW_HALT : RW_8;
            wr_flag    = 1'b0;
            dc_flag    = 1'b0;
        end
    end
endmodule

// File: rtl/bus_ctl_driver.sv
// Module: bus_ctl_driver (top)
// Drives the control pins of a multiplexed external bus for 8/16/32-bit
// regions, with a hold handshake that releases the pins between transactions.
// Assumes aligned requests; a width code of 11 on the request is treated as 32-bit.
module bus_ctl_driver
    import bcd_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_addr_lo,
    input  logic [3:0]        req_mask,
    input  logic              req_write,
    input  logic              req_data,
    input  logic [1:0]        req_width,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              halted,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic [1:0]        bus_phase,
    output logic [3:0]        be_n,
    output logic [1:0]        width_code,
    output logic              wr_flag,
    output logic              dc_flag,
    output logic              ctl_oe
);
    phase_e     phase;
    logic       accept;
    logic       beat_adv;
    attr_t      attr;
    logic [1:0] alo;
    logic       halt_q;
    wcode_e     req_wcode;

    // Purpose: normalise the requested width code.
    always_comb begin
        req_wcode = (req_width == 2'b11) ? RW_32 : wcode_e'(req_width);
    end

    // Purpose: register the halted indication.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= halted;
    end

    bcd_seq #(.BEAT_W(BEAT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .hold_req  (hold_req),
        .req_beats (req_beats),
        .phase     (phase),
        .accept    (accept),
        .beat_adv  (beat_adv)
    );

    bcd_attr u_attr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .beat_adv  (beat_adv),
        .req_mask  (req_mask),
        .req_width (req_wcode),
        .req_wr    (req_write),
        .req_dc    (req_data),
        .req_alo   (req_addr_lo),
        .attr      (attr),
        .alo       (alo)
    );

    bcd_lane_map u_map (
        .phase      (phase),
        .attr       (attr),
        .alo        (alo),
        .halt_q     (halt_q),
        .be_n       (be_n),
        .width_code (width_code),
        .wr_flag    (wr_flag),
        .dc_flag    (dc_flag)
    );

    // Purpose: handshake and phase reporting.
    always_comb begin
        req_ready = (phase == PH_IDLE) && !hold_req;
        hold_ack  = (phase == PH_HOLD);
        ctl_oe    = !hold_ack;
        case (phase)
            PH_ADDR:  bus_phase = 2'b01;
            PH_DATA:  bus_phase = 2'b10;
            PH_RECOV: bus_phase = 2'b11;
            default:  bus_phase = 2'b00;
        endcase
    end

    // R7: enables stay stable across 32-bit data beats.
    a_r7_wide_be_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_phase == 2'b10) && ($past(bus_phase) == 2'b10) && (width_code == 2'b10))
        |-> $stable(be_n));

    // R9: acknowledge always comes with the pins released.
    a_r9_ack_floats: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !ctl_oe);

    // R3: parked pins are high on an 8-bit region during a transaction.
    a_r3_narrow_parked: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_phase != 2'b00) && (width_code == 2'b00)) |-> (be_n[3:2] == 2'b11));

    // R4: the halted code appears only outside a transaction.
    a_r4_halt_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (width_code == 2'b11) |-> (bus_phase == 2'b00));

    // R10: ready only while idle and not held.
    a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((bus_phase == 2'b00) && !hold_ack && !hold_req));
endmodule

// File: tb/sim_bus_ctl_driver.sv
`timescale 1ns/1ps
module sim_bus_ctl_driver;
    localparam int BEAT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_addr_lo = 2'd0;
    logic [3:0]        req_mask = 4'd0;
    logic              req_write = 1'b0;
    logic              req_data = 1'b0;
    logic [1:0]        req_width = 2'd0;
    logic [BEAT_W-1:0] req_beats = '0;
    logic              halted = 1'b0;
    logic              hold_req = 1'b0;
    logic              hold_ack;
    logic [1:0]        bus_phase;
    logic [3:0]        be_n;
    logic [1:0]        width_code;
    logic              wr_flag;
    logic              dc_flag;
    logic              ctl_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bus_ctl_driver #(.BEAT_W(BEAT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr_lo(req_addr_lo), .req_mask(req_mask), .req_write(req_write),
        .req_data(req_data), .req_width(req_width), .req_beats(req_beats),
        .halted(halted), .hold_req(hold_req), .hold_ack(hold_ack),
        .bus_phase(bus_phase), .be_n(be_n), .width_code(width_code),
        .wr_flag(wr_flag), .dc_flag(dc_flag), .ctl_oe(ctl_oe)
    );

    // Behavioural reference state: 0 idle, 1 addr, 2 data, 3 recovery, 4 hold.
    int       m_ph = 0;
    int       m_left = 0;
    int       m_width = 0;
    bit [3:0] m_mask = 0;
    bit       m_wr = 0, m_dc = 0, m_halt = 0;
    int       m_alo = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_width = 0; m_mask = 0;
            m_wr = 0; m_dc = 0; m_halt = 0; m_alo = 0;
        end else begin
            m_halt = halted;
            case (m_ph)
                0: if (hold_req) m_ph = 4;
                   else if (req_valid) begin
                       m_ph = 1; m_left = int'(req_beats);
                       m_width = (req_width == 2'b11) ? 2 : int'(req_width);
                       m_mask = req_mask; m_wr = req_write; m_dc = req_data;
                       m_alo = int'(req_addr_lo);
                   end
                1: m_ph = 2;
                2: if (m_left == 0) m_ph = 3;
                   else begin
                       m_left = m_left - 1;
                       if (m_width == 0) m_alo = (m_alo + 1) % 4;
                       else if (m_width == 1) m_alo = (m_alo + 2) % 4;
                   end
                3: m_ph = hold_req ? 4 : 0;
                default: if (!hold_req) m_ph = 0;
            endcase
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    // Compare all outputs against the reference on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit   strobe;
            bit   busy;
            int   e_be;
            int   e_ph;
            string be_tag;
            strobe = (m_ph == 1) || (m_ph == 2);
            busy   = strobe || (m_ph == 3);
            e_ph   = (m_ph == 4) ? 0 : m_ph;
            e_be   = 15;
            be_tag = "R7 idle/recovery enables";
            if (strobe) begin
                if (m_width == 2) begin
                    e_be = int'(~m_mask) & 15; be_tag = "R1 32-bit lanes";
                end else if (m_width == 1) begin
                    e_be = ((m_mask[1] ? 0 : 8) | 4 | ((m_alo / 2) * 2) | (m_mask[0] ? 0 : 1));
                    be_tag = "R2/R8 16-bit strobes and A1";
                end else begin
                    e_be = 12 | m_alo; be_tag = "R3/R8 8-bit address bits";
                end
            end
            check(be_tag, int'(be_n), e_be);
            check("R4 width code", int'(width_code), busy ? m_width : (m_halt ? 3 : 0));
            check("R5 phase", int'(bus_phase), e_ph);
            check("R6 write flag", int'(wr_flag), busy ? int'(m_wr) : 0);
            check("R6 data flag", int'(dc_flag), busy ? int'(m_dc) : 0);
            check("R9 hold ack", int'(hold_ack), (m_ph == 4) ? 1 : 0);
            check("R9 output enable", int'(ctl_oe), (m_ph == 4) ? 0 : 1);
            check("R10 ready", int'(req_ready), ((m_ph == 0) && !hold_req) ? 1 : 0);
        end
    end

    task automatic issue(int w, int alo, int mask, bit wr, bit dc, int beats);
        @(negedge clk); #1;
        req_valid = 1'b1; req_width = 2'(w); req_addr_lo = 2'(alo);
        req_mask = 4'(mask); req_write = wr; req_data = dc; req_beats = BEAT_W'(beats);
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bus_phase == 2'b00 && !hold_ack) break;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R11: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 be_n in reset", int'(be_n), 15);
        check("R11 wr in reset", int'(wr_flag), 0);
        check("R11 dc in reset", int'(dc_flag), 0);
        check("R11 width in reset", int'(width_code), 0);
        check("R11 ack in reset", int'(hold_ack), 0);
        check("R11 oe in reset", int'(ctl_oe), 1);
        check("R11 phase in reset", int'(bus_phase), 0);
        #1; rst_n = 1'b1;

        // R1, R5, R6, R7: 32-bit write burst of 4 beats.
        issue(2, 0, 4'b1010, 1'b1, 1'b1, 3);
        wait_idle();
        // R2, R8: 16-bit instruction burst, A1 toggles.
        issue(1, 0, 4'b0011, 1'b0, 1'b0, 3);
        wait_idle();
        // R3, R8: 8-bit burst starting at 1, wraps through 0.
        issue(0, 1, 4'b0001, 1'b1, 1'b1, 4);
        wait_idle();
        // R2: single beat, high byte only, address 2.
        issue(1, 2, 4'b0010, 1'b0, 1'b1, 0);
        wait_idle();
        // R9: hold arrives mid-burst; granted after recovery.
        issue(2, 0, 4'b1111, 1'b0, 1'b1, 5);
        @(negedge clk); #1; hold_req = 1'b1;
        // R10: request while busy is ignored.
        req_valid = 1'b1; req_width = 2'd0; req_mask = 4'b0101;
        @(negedge clk); #1; req_valid = 1'b0;
        repeat (10) @(negedge clk);
        // R10: request while held is ignored.
        #1; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1; req_valid = 1'b0; hold_req = 1'b0;
        wait_idle();
        // R9: hold from idle, then release.
        @(negedge clk); #1; hold_req = 1'b1;
        repeat (4) @(negedge clk);
        #1; hold_req = 1'b0;
        wait_idle();
        // R4: halted code while idle, width code during a transaction.
        @(negedge clk); #1; halted = 1'b1;
        repeat (3) @(negedge clk);
        issue(0, 3, 4'b0000, 1'b0, 1'b0, 1);
        wait_idle();
        repeat (2) @(negedge clk);
        #1; halted = 1'b0;
        repeat (3) @(negedge clk);
        // R1: 32-bit read, sparse mask, back-to-back with a 16-bit request.
        issue(2, 0, 4'b0100, 1'b0, 1'b1, 1);
        wait_idle();
        issue(1, 2, 4'b0001, 1'b1, 1'b1, 2);
        wait_idle();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule